// File: doc/BRIEF.md
# General-purpose I/O port with atomic set and clear

This block is a parameterized general-purpose I/O port that sits on a simple word-addressed register bus. Each GPIO line has an output latch bit, which drives the pin value, and a direction bit, which drives the pin's output enable. Software can load the latch in one write or change it atomically through write-one-to-set and write-one-to-clear registers. This removes read-modify-write races when several agents share the port.

The direction can be written through either of two registers. One holds 1 for output. The other holds 1 for input. Both read back as exact complements of one stored direction vector, so they can never disagree. Input pins pass through a two-flop synchronizer before software can read them.

A build option reverses the bit order, so that line n sits at register bit (REG_W-1-n). A second option lets a read of the set register return the output latch. A port can also be built with fewer lines than the register width.

Top module: `gpio_setclr`

## Requirements
- R1: After reset every output latch bit is 0 and every line is an input: `pin_out` and `pin_oe` are all zero, the output-direction register (offset 3) reads 0, and the input-direction register (offset 4) reads 1 on every implemented line bit.
- R2: A write to the data register (offset 0) loads every line of the output latch from the written word in one cycle.
- R3: A write to the set register (offset 1) drives high every line whose bit is 1 and leaves lines written as 0 unchanged.
- R4: A write to the clear register (offset 2) drives low every line whose bit is 1 and leaves lines written as 0 unchanged. A read of offset 2 returns 0.
- R5: A write to the output-direction register (offset 3) sets `pin_oe` for line n to the written bit, where 1 means output. Afterwards offset 3 reads that value and offset 4 reads its bitwise complement.
- R6: A write to the input-direction register (offset 4) sets `pin_oe` for line n to the inverse of the written bit, where 1 means input. Afterwards offset 4 reads that value and offset 3 reads its complement.
- R7: A read of the data register returns the `pin_in` levels after a two-flop synchronizer. Read data appears on `bus_rdata` in the cycle after the request. A pin change made in the same cycle as a read request is not seen by that read.
- R8: With set readback enabled (`SET_READBACK`=1), a read of offset 1 returns the output latch. With it disabled, the read returns 0.
- R9: With `MIRROR`=1, line n corresponds to bit (REG_W-1-n) in every register. With `MIRROR`=0, line n corresponds to bit n.
- R10: When `N_LINES` < `REG_W`, register bits that map to no line read 0, and written values in them have no effect.
- R11: A read of an unmapped offset (5 to 7) returns 0, and a write to one changes neither the latch nor the direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data, valid the cycle after a read request, 0 otherwise |
| pin_in | input | N_LINES | Asynchronous pin levels |
| pin_out | output | N_LINES | Output latch value per line |
| pin_oe | output | N_LINES | Output enable per line, 1 = driven |

## Verification
The mirrored order, the narrow port and set readback disabled are build-time choices, so the port cannot switch into them. The bench therefore runs a second instance built with a mirrored, 12-line, 16-bit configuration beside the default one.

The synchronizer latency is hard to see from the bus, because read data is itself registered. The bench changes a pin in the same cycle as a read request and confirms that this read still returns the old level. A later read then returns the new level.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
    // Word offsets of the registers; software depends on these values.
    localparam int OFS_DATA  = 0;
    localparam int OFS_SET   = 1;
    localparam int OFS_CLR   = 2;
    localparam int OFS_DIROE = 3;
    localparam int OFS_DIRIN = 4;
    localparam int OFS_LAST  = OFS_DIRIN;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpio_line_map.sv
// Register word to line vector.
module gpio_line_map #(
    parameter int REG_W   = 32,
    parameter int N_LINES = 32,
    parameter int MIRROR  = 0
) (
    input  logic [REG_W-1:0]   word_i,
    output logic [N_LINES-1:0] lines_o
);
    for (genvar n = 0; n < N_LINES; n++) begin : g_line
        localparam int BITPOS = (MIRROR != 0) ? (REG_W - 1 - n) : n;
        assign lines_o[n] = word_i[BITPOS];
    end
endmodule

// File: rtl/gpio_line_unmap.sv
// Line vector to register word; bits that hold no line read zero.
module gpio_line_unmap #(
    parameter int REG_W   = 32,
    parameter int N_LINES = 32,
    parameter int MIRROR  = 0
) (
    input  logic [N_LINES-1:0] lines_i,
    output logic [REG_W-1:0]   word_o
);
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        localparam int LINE = (MIRROR != 0) ? (REG_W - 1 - b) : b;
        if (LINE < N_LINES) begin : g_used
            assign word_o[b] = lines_i[LINE];
        end else begin : g_pad
            assign word_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_setclr_core.sv
module gpio_setclr_core
    import gpio_setclr_pkg::*;
#(
    parameter int N_LINES      = 32,
    parameter int ADDR_W       = 3,
    parameter int SET_READBACK = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [N_LINES-1:0] wr_lines,
    input  logic [N_LINES-1:0] in_lines,
    output logic [N_LINES-1:0] latch_o,
    output logic [N_LINES-1:0] dir_o,
    output logic [N_LINES-1:0] rd_lines
);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_DIROE = ADDR_W'(OFS_DIROE);
    localparam logic [ADDR_W-1:0] A_DIRIN = ADDR_W'(OFS_DIRIN);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(OFS_LAST);

    typedef struct packed {
        logic [N_LINES-1:0] latch;
        logic [N_LINES-1:0] dir;
        logic [N_LINES-1:0] rd;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.rd = '0;
        if (req && we) begin
            case (addr)
                A_DATA:  st_d.latch = wr_lines;
                A_SET:   st_d.latch = st_q.latch | wr_lines;
                A_CLR:   st_d.latch = st_q.latch & ~wr_lines;
                A_DIROE: st_d.dir   = wr_lines;
                A_DIRIN: st_d.dir   = ~wr_lines;
                default: ;
            endcase
        end
        if (req && !we) begin
            case (addr)
                A_DATA:  st_d.rd = in_lines;
                A_SET:   st_d.rd = (SET_READBACK != 0) ? st_q.latch : '0;
                A_DIROE: st_d.rd = st_q.dir;
                A_DIRIN: st_d.rd = ~st_q.dir;
                default: st_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o  = st_q.latch;
    assign dir_o    = st_q.dir;
    assign rd_lines = st_q.rd;

    // R3: a set write never lowers a line
    assert_set_keeps_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == A_SET) |=> ((latch_o & $past(latch_o)) == $past(latch_o)));

    // R4: a clear write never raises a line
    assert_clr_keeps_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == A_CLR) |=> ((latch_o & ~$past(latch_o)) == '0));

    // R6: an input-direction write drives the inverted enables
    assert_dirin_inverts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == A_DIRIN) |=> (dir_o == ~$past(wr_lines)));

    // R11: writes to unmapped offsets leave the state alone
    assert_unmapped_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr > A_LAST) |=> ($stable(latch_o) && $stable(dir_o)));

    // R11: reads of unmapped offsets return zero
    assert_unmapped_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr > A_LAST) |=> (rd_lines == '0));
endmodule

// File: rtl/gpio_setclr.sv
module gpio_setclr #(
    parameter int REG_W        = 32,
    parameter int N_LINES      = REG_W,
    parameter int ADDR_W       = 3,
    parameter int MIRROR       = 0,
    parameter int SET_READBACK = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [N_LINES-1:0] pin_in,
    output logic [N_LINES-1:0] pin_out,
    output logic [N_LINES-1:0] pin_oe
);
    logic [N_LINES-1:0] wr_lines;
    logic [N_LINES-1:0] in_sync;
    logic [N_LINES-1:0] rd_lines;

    gpio_line_map #(.REG_W(REG_W), .N_LINES(N_LINES), .MIRROR(MIRROR)) u_wmap (
        .word_i  (bus_wdata),
        .lines_o (wr_lines)
    );

    gpio_sync2 #(.W(N_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (in_sync)
    );

    gpio_setclr_core #(
        .N_LINES(N_LINES), .ADDR_W(ADDR_W), .SET_READBACK(SET_READBACK)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_sel),
        .we       (bus_we),
        .addr     (bus_addr),
        .wr_lines (wr_lines),
        .in_lines (in_sync),
        .latch_o  (pin_out),
        .dir_o    (pin_oe),
        .rd_lines (rd_lines)
    );

    gpio_line_unmap #(.REG_W(REG_W), .N_LINES(N_LINES), .MIRROR(MIRROR)) u_rmap (
        .lines_i (rd_lines),
        .word_o  (bus_rdata)
    );

    // R1: out of reset nothing is driven
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/gpio_setclr_test.sv
`timescale 1ns/1ps
module gpio_setclr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_a = 1'b0, sel_b = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a;
    logic [15:0] rdata_b;
    logic [31:0] pin_in_a = '0;
    logic [31:0] out_a, oe_a;
    logic [11:0] pin_in_b = '0;
    logic [11:0] out_b, oe_b;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_setclr uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .pin_in(pin_in_a),
        .pin_out(out_a), .pin_oe(oe_a)
    );

    gpio_setclr #(.REG_W(16), .N_LINES(12), .MIRROR(1), .SET_READBACK(0)) uut_m (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata[15:0]), .bus_rdata(rdata_b), .pin_in(pin_in_b),
        .pin_out(out_b), .pin_oe(oe_b)
    );

    typedef struct packed {
        logic [2:0]  a;
        logic [31:0] w;
        logic [31:0] exp_out;
        logic [31:0] exp_oe;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [0:NV-1] = '{
        '{3'd0, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000},
        '{3'd1, 32'h0000_0F00, 32'h0000_0FFF, 32'h0000_0000},
        '{3'd2, 32'h0000_00F0, 32'h0000_0F0F, 32'h0000_0000},
        '{3'd1, 32'h0000_0000, 32'h0000_0F0F, 32'h0000_0000},
        '{3'd2, 32'h0000_0000, 32'h0000_0F0F, 32'h0000_0000},
        '{3'd3, 32'hFFFF_0000, 32'h0000_0F0F, 32'hFFFF_0000},
        '{3'd4, 32'hFFFF_FFF0, 32'h0000_0F0F, 32'h0000_000F},
        '{3'd5, 32'hFFFF_FFFF, 32'h0000_0F0F, 32'h0000_000F},
        '{3'd1, 32'h8000_0000, 32'h8000_0F0F, 32'h0000_000F},
        '{3'd2, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_000F}
    };

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input bit m, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sel_a = !m; sel_b = m; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input bit m, input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        sel_a = !m; sel_b = m; we = 1'b0; addr = a;
        @(negedge clk);
        d = m ? {16'h0, rdata_b} : rdata_a;
        sel_a = 1'b0; sel_b = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", out_a, 32'h0);
        check("R1", oe_a, 32'h0);
        bus_rd(0, 3'd3, r); check("R1", r, 32'h0);
        bus_rd(0, 3'd4, r); check("R1", r, 32'hFFFF_FFFF);

        // Vector walk on the default instance
        for (int i = 0; i < NV; i++) begin
            bus_wr(0, VEC[i].a, VEC[i].w);
            check(tag_of(VEC[i].a), out_a, VEC[i].exp_out);
            check(tag_of(VEC[i].a), oe_a, VEC[i].exp_oe);
            bus_rd(0, 3'd1, r); check("R8", r, VEC[i].exp_out);
            bus_rd(0, 3'd3, r); check(tag_of(VEC[i].a), r, VEC[i].exp_oe);
            bus_rd(0, 3'd4, r); check(tag_of(VEC[i].a), r, ~VEC[i].exp_oe);
        end

        // R4 clear register reads zero; R11 unmapped read zero
        bus_wr(0, 3'd0, 32'h1234_5678);
        bus_rd(0, 3'd2, r); check("R4", r, 32'h0);
        bus_rd(0, 3'd6, r); check("R11", r, 32'h0);
        bus_rd(0, 3'd7, r); check("R11", r, 32'h0);
        check("R2", out_a, 32'h1234_5678);

        // R7 synchronizer latency: same-cycle pin change is not seen
        @(negedge clk);
        pin_in_a = 32'hA5A5_0001;
        sel_a = 1'b1; we = 1'b0; addr = 3'd0;
        @(negedge clk);
        check("R7", rdata_a, 32'h0);
        sel_a = 1'b0;
        repeat (3) @(negedge clk);
        bus_rd(0, 3'd0, r); check("R7", r, 32'hA5A5_0001);

        // R9 mirrored order on the narrow instance
        bus_wr(1, 3'd1, 32'h0000_8000);
        check("R9", {20'h0, out_b}, 32'h001);
        bus_wr(1, 3'd3, 32'h0000_0010);
        check("R9", {20'h0, oe_b}, 32'h800);
        bus_rd(1, 3'd4, r); check("R9", r, 32'h0000_FFE0);
        bus_rd(1, 3'd1, r); check("R8", r, 32'h0);
        pin_in_b = 12'h003;
        repeat (3) @(negedge clk);
        bus_rd(1, 3'd0, r); check("R9", r, 32'h0000_C000);

        // R10 unused low bits ignored on write, zero on read
        bus_wr(1, 3'd0, 32'h0000_FFFF);
        check("R10", {20'h0, out_b}, 32'hFFF);
        bus_wr(1, 3'd2, 32'h0000_000F);
        check("R10", {20'h0, out_b}, 32'hFFF);
        pin_in_b = 12'hFFF;
        repeat (3) @(negedge clk);
        bus_rd(1, 3'd0, r); check("R10", r, 32'h0000_FFF0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule